// File: doc/BRIEF.md
# Sync-Counting Field Timing Divider

This block derives the vertical flyback trigger of a raster display from the line timing instead of a free field oscillator. It counts half-line ticks, so the non-integer field length of 312.5 lines becomes a whole count of 625 ticks. Each field start produces a flyback pulse of fixed length and toggles an odd/even field flag.

A vertical sync pulse, taken from the composite sync separator, is checked against the count. If it arrives close enough to the expected field end, it restarts the field at once. If it arrives anywhere else, it is discarded. When no usable sync arrives, the counter runs on to a longer free-run limit, so triggers never stop and incoming sync can always pull the field into step. A lock flag reports whether recent fields were set by sync.

Top module: `field_sync_divider`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `flyback`, `locked` and `odd_field` are 0, and the half-line count (ticks since field start) is 0.
- R2: With no accepted sync, a field ends on the half-line tick that would take the count to FREE_HALF (632). Back-to-back free-run fields are therefore exactly 632 ticks apart.
- R3: A `vsync` pulse is accepted when the count is in NOM_HALF-WIN .. NOM_HALF+WIN (621..629 inclusive). Acceptance ends the field in that cycle and sets the count to 0.
- R4: A `vsync` pulse outside that window is ignored. It does not change the count, the field timing or the lock state.
- R5: If `vsync` is accepted in the same cycle as a half-line tick, the realignment wins and that tick is not counted. The new field starts at count 0.
- R6: Each field start (accepted sync or free-run wrap) drives `flyback` high from the next cycle for PULSE_US*CLK_MHZ cycles. A new field start during a pulse reloads the full length.
- R7: `odd_field` inverts on every field start and holds at all other times.
- R8: `locked` rises with the LOCK_HITS-th (4th) consecutive accepted sync. Any free-run wrap clears the run of accepted syncs.
- R9: `locked` falls with the UNLOCK_MISSES-th (8th) consecutive free-run wrap. Any accepted sync clears the run of wraps, and ignored syncs count toward neither run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_tick | input | 1 | One-cycle pulse at twice the line rate |
| vsync | input | 1 | One-cycle separated vertical sync pulse |
| flyback | output | 1 | Field flyback trigger pulse |
| locked | output | 1 | Field timing is following incoming sync |
| odd_field | output | 1 | Field parity, toggles every field |

## Verification
Sync acceptance and half-line counting can fall in the same clock cycle. The bench provokes this by firing `vsync` on the very cycle whose tick would move the count out of 625. It judges the result by the spacing between flyback pulses, which must be 626 ticks rather than 625, because the coincident tick is discarded. The same cycle-exact model also checks sync placed at both window edges and one tick beyond them, where a single count of difference separates acceptance from rejection.

// File: rtl/fsd_pkg.sv
package fsd_pkg;
   // field start cause, produced by the half-line counter
   typedef struct packed {
      logic hit;   // accepted in-window sync
      logic wrap;  // free-run limit reached
   } fsd_evt_t;
endpackage

// File: rtl/fsd_halfline_counter.sv
module fsd_halfline_counter
   import fsd_pkg::*;
#(
   parameter int NOM_HALF  = 625,
   parameter int FREE_HALF = 632,
   parameter int WIN       = 4,
   parameter int CW        = $clog2(FREE_HALF)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          half_tick,
   input  logic          vsync,
   output logic [CW-1:0] hcnt,
   output logic          in_win,
   output fsd_evt_t      evt
);
   localparam int WLO = NOM_HALF - WIN;
   localparam int WHI = NOM_HALF + WIN;

   assign in_win   = (hcnt >= CW'(WLO)) && (hcnt <= CW'(WHI));
   assign evt.hit  = vsync && in_win;
   assign evt.wrap = !evt.hit && half_tick && (hcnt == CW'(FREE_HALF - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hcnt <= '0;
      end else if (evt.hit || evt.wrap) begin
         hcnt <= '0;
      end else if (half_tick) begin
         hcnt <= hcnt + 1'b1;
      end
   end
endmodule

// File: rtl/fsd_lock_tracker.sv
module fsd_lock_tracker
   import fsd_pkg::*;
#(
   parameter int LOCK_HITS     = 4,
   parameter int UNLOCK_MISSES = 8
) (
   input  logic     clk,
   input  logic     rst_n,
   input  fsd_evt_t evt,
   output logic     locked
);
   localparam int HW = $clog2(LOCK_HITS + 1);
   localparam int MW = $clog2(UNLOCK_MISSES + 1);

   logic [HW-1:0] hits;
   logic [MW-1:0] misses;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hits   <= '0;
         misses <= '0;
         locked <= 1'b0;
      end else if (evt.hit) begin
         misses <= '0;
         if (hits != HW'(LOCK_HITS)) hits <= hits + 1'b1;
         if (hits >= HW'(LOCK_HITS - 1)) locked <= 1'b1;
      end else if (evt.wrap) begin
         hits <= '0;
         if (misses != MW'(UNLOCK_MISSES)) misses <= misses + 1'b1;
         if (misses >= MW'(UNLOCK_MISSES - 1)) locked <= 1'b0;
      end
   end
endmodule

// File: rtl/fsd_flyback_pulse.sv
module fsd_flyback_pulse #(
   parameter int PULSE_CYC = 2700
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   output logic flyback
);
   generate
      if (PULSE_CYC == 1) begin : g_single
         logic q;
         always_ff @(posedge clk) begin
            if (!rst_n) q <= 1'b0;
            else        q <= trig;
         end
         assign flyback = q;
      end else begin : g_count
         localparam int PW = $clog2(PULSE_CYC + 1);
         logic [PW-1:0] left;
         always_ff @(posedge clk) begin
            if (!rst_n)            left <= '0;
            else if (trig)         left <= PW'(PULSE_CYC);
            else if (left != '0)   left <= left - 1'b1;
         end
         assign flyback = (left != '0);
      end
   endgenerate
endmodule

// File: rtl/field_sync_divider.sv
module field_sync_divider
   import fsd_pkg::*;
#(
   parameter int NOM_HALF      = 625,
   parameter int FREE_HALF     = 632,
   parameter int WIN           = 4,
   parameter int LOCK_HITS     = 4,
   parameter int UNLOCK_MISSES = 8,
   parameter int CLK_MHZ       = 27,
   parameter int PULSE_US      = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic half_tick,
   input  logic vsync,
   output logic flyback,
   output logic locked,
   output logic odd_field
);
   localparam int CW        = $clog2(FREE_HALF);
   localparam int PULSE_CYC = PULSE_US * CLK_MHZ;

   generate
      if (FREE_HALF <= NOM_HALF + WIN) begin : g_bad_free
         $error("free-run limit must exceed the sync window");
      end
      if (WIN < 1 || WIN >= NOM_HALF) begin : g_bad_win
         $error("window half-width out of range");
      end
      if (PULSE_CYC < 1) begin : g_bad_pulse
         $error("flyback pulse must last at least one cycle");
      end
      if (LOCK_HITS < 2 || UNLOCK_MISSES < 2) begin : g_bad_lock
         $error("lock thresholds must be at least 2");
      end
   endgenerate

   logic [CW-1:0] hcnt;
   logic          in_win;
   fsd_evt_t      evt;
   logic          sync_hit;
   logic          free_wrap;
   logic          field_evt;

   fsd_halfline_counter #(
      .NOM_HALF (NOM_HALF),
      .FREE_HALF(FREE_HALF),
      .WIN      (WIN),
      .CW       (CW)
   ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .half_tick(half_tick),
      .vsync    (vsync),
      .hcnt     (hcnt),
      .in_win   (in_win),
      .evt      (evt)
   );

   assign sync_hit  = evt.hit;
   assign free_wrap = evt.wrap;
   assign field_evt = sync_hit | free_wrap;

   fsd_lock_tracker #(
      .LOCK_HITS    (LOCK_HITS),
      .UNLOCK_MISSES(UNLOCK_MISSES)
   ) u_lock (
      .clk   (clk),
      .rst_n (rst_n),
      .evt   (evt),
      .locked(locked)
   );

   fsd_flyback_pulse #(
      .PULSE_CYC(PULSE_CYC)
   ) u_pulse (
      .clk    (clk),
      .rst_n  (rst_n),
      .trig   (field_evt),
      .flyback(flyback)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)         odd_field <= 1'b0;
      else if (field_evt) odd_field <= ~odd_field;
   end
endmodule

// File: rtl/fsd_checker.sv
module fsd_checker #(
   parameter int CW        = 10,
   parameter int FREE_HALF = 632
) (
   input logic          clk,
   input logic          rst_n,
   input logic          half_tick,
   input logic          vsync,
   input logic [CW-1:0] hcnt,
   input logic          in_win,
   input logic          sync_hit,
   input logic          free_wrap,
   input logic          field_evt,
   input logic          flyback,
   input logic          locked,
   input logic          odd_field
);
   assert_count_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      hcnt < CW'(FREE_HALF));

   assert_realign_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (vsync && in_win) |=> (hcnt == '0));

   assert_outside_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (vsync && !in_win && !half_tick) |=> $stable(hcnt));

   assert_flyback_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
      field_evt |=> flyback);

   assert_parity_flip_R7: assert property (@(posedge clk) disable iff (!rst_n)
      field_evt |=> (odd_field != $past(odd_field)));

   assert_parity_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !field_evt |=> $stable(odd_field));

   assert_lock_by_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(sync_hit));

   assert_unlock_by_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(locked) |-> $past(free_wrap));
endmodule

bind field_sync_divider fsd_checker #(
   .CW       (CW),
   .FREE_HALF(FREE_HALF)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .half_tick(half_tick),
   .vsync    (vsync),
   .hcnt     (hcnt),
   .in_win   (in_win),
   .sync_hit (sync_hit),
   .free_wrap(free_wrap),
   .field_evt(field_evt),
   .flyback  (flyback),
   .locked   (locked),
   .odd_field(odd_field)
);

// File: tb/field_sync_divider_tb.sv
`timescale 1ns/1ps
module field_sync_divider_tb;
   localparam int NOM   = 625;
   localparam int FREE  = 632;
   localparam int WIN   = 4;
   localparam int LHITS = 4;
   localparam int UMISS = 8;
   localparam int PULSE = 12;
   localparam int DIV   = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic half_tick = 1'b0;
   logic vsync = 1'b0;
   logic flyback, locked, odd_field;

   always #2 clk = ~clk;

   field_sync_divider #(
      .NOM_HALF(NOM), .FREE_HALF(FREE), .WIN(WIN),
      .LOCK_HITS(LHITS), .UNLOCK_MISSES(UMISS),
      .CLK_MHZ(1), .PULSE_US(PULSE)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .vsync(vsync),
      .flyback(flyback), .locked(locked), .odd_field(odd_field)
   );

   int total = 0;
   int bad = 0;
   string phase_tag = "R1";

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s (phase %s) actual=%0d expected=%0d at cyc", tag, phase_tag, act, exp);
      end
   endtask

   // behavioural reference
   int m_cnt = 0, m_hits = 0, m_miss = 0, m_fly = 0, fields = 0;
   bit m_lock = 0, m_odd = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_hits = 0; m_miss = 0; m_fly = 0; m_lock = 0; m_odd = 0;
      end else begin
         bit hit, wrap;
         hit = 0; wrap = 0;
         if (vsync && m_cnt >= NOM - WIN && m_cnt <= NOM + WIN) begin
            hit = 1; m_cnt = 0;
         end else if (half_tick) begin
            if (m_cnt == FREE - 1) begin wrap = 1; m_cnt = 0; end
            else m_cnt++;
         end
         if (hit) begin
            m_miss = 0;
            if (m_hits < LHITS) m_hits++;
            if (m_hits >= LHITS) m_lock = 1;
         end
         if (wrap) begin
            m_hits = 0;
            if (m_miss < UMISS) m_miss++;
            if (m_miss >= UMISS) m_lock = 0;
         end
         if (hit || wrap) begin
            m_odd = !m_odd; m_fly = PULSE; fields++;
         end else if (m_fly > 0) m_fly--;
      end
   end

   // stimulus, per-cycle comparison, interval measurement
   int cyc = 0;
   int sync_at = -1;
   int sync_ph = 2;
   bit fired = 0;
   int seen_fields = 0;
   bit prev_fly = 0;
   int last_rise = -1;
   int last_interval = 0;
   bit done = 0;

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R6 flyback", flyback, (m_fly != 0));
         chk("R7 odd_field", odd_field, m_odd);
         chk("R8 R9 locked", locked, m_lock);
         if (flyback && !prev_fly) begin
            if (last_rise >= 0) last_interval = cyc - last_rise;
            last_rise = cyc;
         end
         prev_fly = flyback;
      end
      if (fields != seen_fields) begin
         seen_fields = fields;
         fired = 0;
      end
      cyc++;
      half_tick <= rst_n && (cyc % DIV == 0);
      if (rst_n && !fired && sync_at >= 0 && m_cnt == sync_at && (cyc % DIV) == sync_ph) begin
         vsync <= 1'b1;
         fired = 1;
      end else begin
         vsync <= 1'b0;
      end
   end

   task automatic wait_fields(input int n);
      int target;
      target = fields + n;
      while (fields < target) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      forever begin
         @(negedge clk);
         if (cyc > 190000 && !done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=%0d expected<190000", cyc);
            finish_run();
         end
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      chk("R1 flyback in reset", flyback, 0);
      chk("R1 locked in reset", locked, 0);
      chk("R1 odd_field in reset", odd_field, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 flyback after reset", flyback, 0);
      chk("R1 odd_field after reset", odd_field, 0);

      phase_tag = "R2";
      wait_fields(3);
      chk("R2 free-run field length", last_interval, FREE * DIV);

      phase_tag = "R8";
      sync_at = NOM; sync_ph = 2;
      wait_fields(3);
      chk("R8 no lock after 3 hits", locked, 0);
      chk("R3 synced field length", last_interval, NOM * DIV);
      wait_fields(3);
      chk("R8 lock after 4+ hits", locked, 1);

      phase_tag = "R5";
      sync_ph = 0;
      wait_fields(3);
      chk("R5 coincident tick discarded", last_interval, (NOM + 1) * DIV);

      phase_tag = "R3";
      sync_ph = 2; sync_at = NOM - WIN;
      wait_fields(2);
      chk("R3 low window edge", last_interval, (NOM - WIN) * DIV);
      sync_at = NOM + WIN;
      wait_fields(2);
      chk("R3 high window edge", last_interval, (NOM + WIN) * DIV);
      chk("R3 lock kept", locked, 1);

      phase_tag = "R4";
      sync_at = 300;
      wait_fields(3);
      chk("R4 mid-field sync ignored", last_interval, FREE * DIV);
      sync_at = NOM + WIN + 1;
      wait_fields(2);
      chk("R4 sync past window ignored", last_interval, FREE * DIV);
      sync_at = NOM - WIN - 1;
      wait_fields(1);
      chk("R4 sync before window ignored", last_interval, FREE * DIV);
      chk("R4 lock kept after 6 misses", locked, 1);

      phase_tag = "R9";
      sync_at = NOM;
      wait_fields(1);
      sync_at = -1;
      wait_fields(7);
      chk("R9 hit cleared miss run", locked, 1);
      wait_fields(1);
      chk("R9 unlock after 8 misses", locked, 0);

      finish_run();
   end
endmodule